// File: doc/BRIEF.md
# Paired-Register Doubleword Load/Store Sequencer

This block carries out one 64-bit load or store as two 32-bit transfers over a single-port word memory interface. The request names a base value, a signed 16-bit displacement and an even register number. That register and the next one up form the pair that holds the doubleword. The effective address is always rounded down to a word boundary.

A load reads the lower word first and hands it back for the odd register. It then reads the upper word, which goes to the even register. A store runs in the opposite direction: it writes the upper word from the even register first, then the lower word from the odd register. Each transfer holds its request until the memory answers with ready.

Read data is registered before it leaves the block. The second write-back therefore lands in the same cycle as the completion pulse, which is the source of the load-delay slot seen by the issuing pipeline. An odd register number is rejected at once with an error flag, and no memory traffic follows. A zero base makes the displacement alone the address.

Top module: `dwl_seq`

## Requirements
- R1: The effective address is (baseVal + sign-extended offsetVal) with bits [1:0] cleared. The two transfers use this address and this address + 4.
- R2: A load reads the aligned address first and returns that word with wbReg = regNum+1. It then reads address + 4 and returns that word with wbReg = regNum.
- R3: A store writes storeEven (the data of regNum) to address + 4 first, then writes storeOdd (the data of regNum+1) to the aligned address. memWe is 1 on both store transfers and 0 on both load transfers.
- R4: When regNum[0] is 1 at start, oddErr and done pulse together one cycle after start, and memReq is never raised for that request.
- R5: During a transfer, memReq, memAddr, memWe and memWdata hold steady until the cycle in which memReady is 1. The transfer completes at that clock edge.
- R6: busy is 1 from the cycle after an accepted start up to and including the done cycle, and is 0 once the block is idle again.
- R7: A start pulse that arrives while busy is ignored. The transfers, data and write-backs of the running request are unchanged.
- R8: done is a single-cycle pulse in the cycle after the second transfer completes. Each load write-back (wbValid) appears in the cycle after its transfer completes, so the second one coincides with done.
- R9: With baseVal = 0 the offset alone sets the address. For example, offset 0x8006 gives 0xFFFF8004 and offset 0x0013 gives 0x00000010.
- R10: After reset, busy, memReq, done, wbValid and oddErr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begins a request when the block is idle |
| isStore | input | 1 | 1 for store, 0 for load |
| baseVal | input | 32 | Base register value |
| offsetVal | input | 16 | Signed displacement |
| regNum | input | 5 | Even register number of the pair |
| storeEven | input | 32 | Store data of register regNum |
| storeOdd | input | 32 | Store data of register regNum+1 |
| memReady | input | 1 | Memory completes the current transfer |
| memRdata | input | 32 | Memory read data |
| memReq | output | 1 | Transfer request |
| memAddr | output | 32 | Word-aligned transfer address |
| memWe | output | 1 | Write enable |
| memWdata | output | 32 | Write data |
| wbValid | output | 1 | Register write-back strobe |
| wbReg | output | 5 | Register number being written back |
| wbData | output | 32 | Write-back data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request completion pulse |
| oddErr | output | 1 | Odd register number rejected |

## Verification
The bench sweeps every register number, both directions and memory latencies of zero to two wait cycles. Each combination runs with displacements that are zero, positive unaligned, large positive and negative unaligned. Odd register numbers separate the rejection path from the sequencing path. The mixed-sign displacements expose a missing sign extension or alignment mask. Read data that depends on the address shows whether the crossed odd/even pairing and the transfer order are correct. The sweep also varies latency to catch completion or write-back timing that counts cycles instead of following ready. Separate runs use a zero base and inject a second start part-way through a request.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACC1 = 3'd1,
    ST_ACC2 = 3'd2,
    ST_FIN  = 3'd3,
    ST_ERR  = 3'd4
  } dwlState_t;

  typedef struct packed {
    logic latch;   // capture request fields
    logic req;     // a transfer is presented
    logic phase2;  // second transfer of the pair
    logic take;    // transfer completes at this edge
  } dwlStrobe_t;
endpackage

// File: rtl/dwl_ctrl.sv
module dwl_ctrl
  import dwl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       regOdd,
  input  logic       memReady,
  output dwlStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       oddErr
);
  dwlState_t state, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.latch = 1'b1;
          nxtState     = regOdd ? ST_ERR : ST_ACC1;
        end
      end
      ST_ACC1: begin
        strobe.req = 1'b1;
        if (memReady) nxtState = ST_ACC2;
      end
      ST_ACC2: begin
        strobe.req    = 1'b1;
        strobe.phase2 = 1'b1;
        if (memReady) nxtState = ST_FIN;
      end
      ST_FIN:  nxtState = ST_IDLE;
      ST_ERR:  nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
    strobe.take = strobe.req & memReady;
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN) || (state == ST_ERR);
  assign oddErr = (state == ST_ERR);

  // R5: a transfer without ready stays in the same phase
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.req && !memReady) |=> (strobe.req && state == $past(state)));

  // R8: completion lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: the rejection cycle is followed by no transfer
  p_err_noacc_r4: assert property (@(posedge clk) disable iff (!rstN)
    oddErr |=> !strobe.req);

  // R7: a start during the first transfer does not disturb it
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACC1 && startPulse && !memReady) |=> (state == ST_ACC1));

  // R6: done never occurs while idle
  p_busy_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
endmodule

// File: rtl/dwl_path.sv
module dwl_path
  import dwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwlStrobe_t        strobe,
  input  logic              isStore,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offsetVal,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] storeEven,
  input  logic [DATA_W-1:0] storeOdd,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbData
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ALIGN_W    = $clog2(WORD_BYTES);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_W) - DATA_W'(1));
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

  logic              opStore;
  logic [DATA_W-1:0] eaReg;
  logic [REG_W-1:0]  rnReg;
  logic [DATA_W-1:0] dEven, dOdd;
  logic [DATA_W-1:0] extOff;
  logic              useHigh;

  assign extOff = {{(DATA_W-OFF_W){offsetVal[OFF_W-1]}}, offsetVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opStore <= 1'b0;
      eaReg   <= '0;
      rnReg   <= '0;
      dEven   <= '0;
      dOdd    <= '0;
    end else if (strobe.latch) begin
      opStore <= isStore;
      eaReg   <= (baseVal + extOff) & ALIGN_MASK;
      rnReg   <= regNum;
      dEven   <= storeEven;
      dOdd    <= storeOdd;
    end
  end

  // load: lower word then upper; store: upper word then lower
  assign useHigh  = strobe.phase2 ^ opStore;
  assign memReq   = strobe.req;
  assign memWe    = strobe.req & opStore;
  assign memAddr  = useHigh ? (eaReg + STEP) : eaReg;
  assign memWdata = useHigh ? dEven : dOdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbReg   <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= strobe.take & ~opStore;
      if (strobe.take & ~opStore) begin
        wbReg  <= useHigh ? rnReg : (rnReg | REG_W'(1));
        wbData <= memRdata;
      end
    end
  end

  // R5: a pending transfer keeps its address and data
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.req && !strobe.take) |=> ($stable(memAddr) && $stable(memWdata) && $stable(memWe)));

  // R8: a write-back follows a completed read by one cycle
  p_wb_after_take_r8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> ($past(strobe.take) && !opStore));

  // R3: stores never produce write-backs
  p_store_no_wb_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.req && opStore) |=> !wbValid);
endmodule

// File: rtl/dwl_seq.sv
module dwl_seq
  import dwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              isStore,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offsetVal,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] storeEven,
  input  logic [DATA_W-1:0] storeOdd,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbData,
  output logic              busy,
  output logic              done,
  output logic              oddErr
);
  dwlStrobe_t strobe;

  dwl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .regOdd     (regNum[0]),
    .memReady   (memReady),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .oddErr     (oddErr)
  );

  dwl_path #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .REG_W  (REG_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .isStore   (isStore),
    .baseVal   (baseVal),
    .offsetVal (offsetVal),
    .regNum    (regNum),
    .storeEven (storeEven),
    .storeOdd  (storeOdd),
    .memRdata  (memRdata),
    .memReq    (memReq),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .wbValid   (wbValid),
    .wbReg     (wbReg),
    .wbData    (wbData)
  );

  // R4: no transfer is requested in the same cycle as a rejection
  p_odd_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    oddErr |-> (!memReq && done));
endmodule

// File: tb/sim_dwl_seq.sv
`timescale 1ns/1ps
module sim_dwl_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        isStore = 1'b0;
  logic [31:0] baseVal = '0;
  logic [15:0] offsetVal = '0;
  logic [4:0]  regNum = '0;
  logic [31:0] storeEven = '0;
  logic [31:0] storeOdd = '0;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memReq, memWe, wbValid, busy, done, oddErr;
  logic [31:0] memAddr, memWdata, wbData;
  logic [4:0]  wbReg;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dwl_seq u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .isStore(isStore),
    .baseVal(baseVal), .offsetVal(offsetVal), .regNum(regNum),
    .storeEven(storeEven), .storeOdd(storeOdd), .memReady(memReady),
    .memRdata(memRdata), .memReq(memReq), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
    .busy(busy), .done(done), .oddErr(oddErr)
  );

  function automatic logic [31:0] model(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] accAddr[4];
  logic [31:0] accData[4];
  logic        accWe[4];
  logic [4:0]  wbR[4];
  logic [31:0] wbD[4];

  task automatic runOp(input bit st, input logic [31:0] base, input logic [15:0] off,
                       input logic [4:0] rn, input logic [31:0] dE, input logic [31:0] dO,
                       input int lat, input bit inject);
    logic [31:0] ea;
    int nAcc = 0;
    int nWb = 0;
    int doneAt = -1;
    int nDone = 0;
    bit errSeen = 0;
    bit wbAtDone = 0;
    bit busyBad = 0;
    int waitCnt = 0;
    ea = (base + {{16{off[15]}}, off}) & 32'hFFFF_FFFC;
    @(negedge clk);
    isStore = st; baseVal = base; offsetVal = off; regNum = rn;
    storeEven = dE; storeOdd = dO; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      if (!busy) busyBad = 1;
      if (wbValid && nWb < 4) begin wbR[nWb] = wbReg; wbD[nWb] = wbData; nWb++; end
      if (done) begin
        nDone++; doneAt = cyc; errSeen = oddErr; wbAtDone = wbValid;
      end
      if (memReq) begin
        if (waitCnt == lat) begin
          memReady = 1'b1; memRdata = model(memAddr);
          if (nAcc < 4) begin
            accAddr[nAcc] = memAddr; accData[nAcc] = memWdata; accWe[nAcc] = memWe;
          end
          nAcc++; waitCnt = 0;
        end else begin
          memReady = 1'b0; memRdata = 32'hDEAD_BEEF; waitCnt++;
        end
      end else begin
        memReady = 1'b0;
      end
      if (inject && cyc == 1) begin
        startPulse = 1'b1; isStore = ~st; regNum = rn ^ 5'd2; baseVal = base + 32'h100;
      end else begin
        startPulse = 1'b0;
      end
      @(negedge clk);
      if (doneAt >= 0) break;
    end
    memReady = 1'b0;
    startPulse = 1'b0;
    chk(nDone == 1, "R8 done count", nDone, 1);
    chk(!busy && !done && !oddErr, "R6 idle after done", {busy, done, oddErr}, 0);
    chk(!busyBad, "R6 busy during request", busyBad, 0);
    if (rn[0]) begin
      chk(doneAt == 0, "R4 reject timing", doneAt, 0);
      chk(errSeen, "R4 oddErr with done", errSeen, 1);
      chk(nAcc == 0, "R4 no transfer", nAcc, 0);
    end else begin
      chk(!errSeen, "R4 no error on even", errSeen, 0);
      chk(nAcc == 2, "R5 transfer count", nAcc, 2);
      chk(doneAt == 2 * (lat + 1), "R8 done timing", doneAt, 2 * (lat + 1));
      if (nAcc == 2) begin
        chk(accAddr[0] == (st ? ea + 4 : ea), inject ? "R7 first addr" : "R1 first addr",
            accAddr[0], st ? ea + 4 : ea);
        chk(accAddr[1] == (st ? ea : ea + 4), inject ? "R7 second addr" : "R1 second addr",
            accAddr[1], st ? ea : ea + 4);
        chk(accWe[0] == st && accWe[1] == st, "R3 write enable", {accWe[0], accWe[1]}, {st, st});
        if (st) begin
          chk(accData[0] == dE, "R3 upper word data", accData[0], dE);
          chk(accData[1] == dO, "R3 lower word data", accData[1], dO);
          chk(nWb == 0, "R3 no write-back", nWb, 0);
        end else begin
          chk(nWb == 2, "R2 write-back count", nWb, 2);
          chk(wbAtDone, "R8 last write-back with done", wbAtDone, 1);
          if (nWb == 2) begin
            chk(wbR[0] == (rn | 5'd1), "R2 first reg", wbR[0], rn | 5'd1);
            chk(wbD[0] == model(ea), "R2 first data", wbD[0], model(ea));
            chk(wbR[1] == rn, "R2 second reg", wbR[1], rn);
            chk(wbD[1] == model(ea + 4), "R2 second data", wbD[1], model(ea + 4));
          end
        end
      end
    end
  endtask

  initial begin
    logic [15:0] offs[4];
    offs[0] = 16'h0000; offs[1] = 16'h0005; offs[2] = 16'h7FFE; offs[3] = 16'h8003;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !memReq && !done && !wbValid && !oddErr, "R10 reset outputs",
        {busy, memReq, done, wbValid, oddErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq, "R10 idle after reset", {busy, memReq}, 0);
    for (int st = 0; st < 2; st++)
      for (int rn = 0; rn < 32; rn++)
        for (int lat = 0; lat < 3; lat++)
          for (int k = 0; k < 4; k++)
            runOp(st[0], 32'h1000_0000 + 32'(rn * 7 + lat), offs[k], 5'(rn),
                  32'hA000_0000 + 32'(rn), 32'hB000_0000 + 32'(k), lat, 1'b0);
    // R9: zero base, the offset alone sets the address
    runOp(1'b1, 32'h0, 16'h8006, 5'd4, 32'h1111_2222, 32'h3333_4444, 0, 1'b0);
    runOp(1'b0, 32'h0, 16'h0013, 5'd10, 32'h0, 32'h0, 1, 1'b0);
    runOp(1'b1, 32'h0, 16'h0013, 5'd30, 32'h5555_6666, 32'h7777_8888, 2, 1'b0);
    // R7: start pulse during a running request
    for (int lat = 0; lat < 3; lat++) begin
      runOp(1'b0, 32'h2000_0040, 16'h0009, 5'd8, 32'h0, 32'h0, lat, 1'b1);
      runOp(1'b1, 32'h2000_0040, 16'hFFF1, 5'd12, 32'hCAFE_0001, 32'hCAFE_0002, lat, 1'b1);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule